// File: doc/BRIEF.md
# Banked Block Memory Mover

This sequencer copies a run of bytes from one 64 KiB bank of a 24-bit byte-addressed memory to another, or within the same bank. It carries out the copy loop of a block-move instruction and nothing else. A start pulse loads the following values:

- the two bank bytes, taken from the instruction operands;
- a source offset and a destination offset, which hold the two index register values;
- a 16-bit count, which holds the accumulator value;
- a direction select;
- an index-width flag.

The block then drives a single-port synchronous memory, one byte per read/write pair. When the copy ends it returns the final offsets, the final count, and a data-bank value equal to the destination bank.

The direction select picks the variant. A value of 0 is the "next" form (opcode 0x54), which walks the offsets upward. A value of 1 is the "previous" form (opcode 0x44), which walks them downward. The copy is sequential, byte after byte, so overlapping regions behave exactly as a byte-at-a-time loop does.

Top module: `blk_mover`

## Requirements
- R1: The move transfers count+1 bytes, so a count of 0 moves one byte. The count output decrements once per write and ends at 0xFFFF.
- R2: The source bank is the second operand byte (`opnd_b_i`) and the destination bank is the first operand byte (`opnd_a_i`). Every memory address is {bank[7:0], offset[15:0]}.
- R3: Each byte is read at {source bank, source offset}. In the cycle after the read it is written at {destination bank, destination offset}, with the read data as write data.
- R4: With `narrow_i`=1 the high byte of both offsets is forced to zero at load. The offsets then wrap within 8 bits and their high byte stays zero.
- R5: With `desc_i`=0 both offsets increment after each write. With `desc_i`=1 both decrement. The final offsets equal start ± (count+1), wrapped.
- R6: With `narrow_i`=0 the offsets wrap within 16 bits and never carry into or borrow from the bank.
- R7: Each byte takes one read cycle (`mem_re_o`) followed by one write cycle (`mem_we_o`), never both at once. `busy_o` rises in the cycle after the start pulse is sampled and stays high for exactly 2*(count+1) cycles.
- R8: `done_o` is high for exactly one cycle, the cycle after the last write, with `busy_o` low.
- R9: When the move ends, `dbank_o` takes the destination bank value.
- R10: A start pulse while the block is busy is ignored. The running move completes with its original parameters and no extra writes.
- R11: After reset `busy_o`, `done_o`, `mem_re_o` and `mem_we_o` are 0, and the offset, count and data-bank outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| desc_i | input | 1 | 0 ascending ("next"), 1 descending ("previous") |
| narrow_i | input | 1 | 1 selects 8-bit offsets |
| opnd_a_i | input | 8 | First operand byte, destination bank |
| opnd_b_i | input | 8 | Second operand byte, source bank |
| src_ofs_i | input | 16 | Source offset at start |
| dst_ofs_i | input | 16 | Destination offset at start |
| cnt_i | input | 16 | Count at start, bytes minus one |
| mem_addr_o | output | 24 | Memory byte address |
| mem_re_o | output | 1 | Read strobe, data returns next cycle |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after the read |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle end pulse |
| src_ofs_o | output | 16 | Current/final source offset |
| dst_ofs_o | output | 16 | Current/final destination offset |
| cnt_o | output | 16 | Current/final count |
| dbank_o | output | 8 | Data bank, destination bank after a move |

## Verification
The bench builds the block with its default widths: 8-bit banks, 16-bit offsets and count, and an 8-bit narrow width. At these widths the real wrap points can be reached with short moves. An offset of 0xFFFE crosses into 0x0000 within a 5-byte copy, and a narrow offset of 0x00FE crosses into 0x0000 just as quickly. Both cases show that no carry reaches the bank. Single-byte, descending, overlapping and start-while-busy moves are all checked against a byte-at-a-time reference copy of the memory.

// File: rtl/blk_mover_pkg.sv
package blk_mover_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_FIN  = 2'd3
  } mv_state_e;
endpackage

// File: rtl/blk_mover_ofs.sv
module blk_mover_ofs #(
  parameter int OFS_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [OFS_W-1:0] val_i,
  input  logic             narrow_i,
  input  logic             step_i,
  input  logic             desc_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] ofs_q, nxt;

  always_comb begin
    nxt = desc_i ? ofs_q - 1'b1 : ofs_q + 1'b1;
    if (narrow_i) nxt[OFS_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q <= '0;
    end else if (load_i) begin
      ofs_q <= narrow_i ? {{(OFS_W-NARROW_W){1'b0}}, val_i[NARROW_W-1:0]} : val_i;
    end else if (step_i) begin
      ofs_q <= nxt;
    end
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/blk_mover_ctl.sv
module blk_mover_ctl
  import blk_mover_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output mv_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o
);
  mv_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_WR);
  assign last_o = step_o && (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD;
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = last_o ? ST_FIN : ST_RD;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      cnt_q <= cnt_i;
      else if (step_o) cnt_q <= cnt_q - 1'b1;  // wraps to all ones after the last byte
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/blk_mover.sv
module blk_mover
  import blk_mover_pkg::*;
#(
  parameter int BANK_W   = 8,
  parameter int OFS_W    = 16,
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter int NARROW_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    desc_i,
  input  logic                    narrow_i,
  input  logic [BANK_W-1:0]       opnd_a_i,
  input  logic [BANK_W-1:0]       opnd_b_i,
  input  logic [OFS_W-1:0]        src_ofs_i,
  input  logic [OFS_W-1:0]        dst_ofs_i,
  input  logic [CNT_W-1:0]        cnt_i,
  output logic [BANK_W+OFS_W-1:0] mem_addr_o,
  output logic                    mem_re_o,
  output logic                    mem_we_o,
  output logic [DATA_W-1:0]       mem_wdata_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [OFS_W-1:0]        src_ofs_o,
  output logic [OFS_W-1:0]        dst_ofs_o,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [BANK_W-1:0]       dbank_o
);
  localparam int NCH = 2;  // channel 0 source, 1 destination

  mv_state_e        state;
  logic             load, step, last;
  logic [BANK_W-1:0] src_bank_q, dst_bank_q, dbank_q;
  logic             desc_q, narrow_q;
  logic [OFS_W-1:0] ofs_in [NCH];
  logic [OFS_W-1:0] ofs_cur[NCH];

  blk_mover_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cnt_i   (cnt_i),
    .state_o (state),
    .cnt_o   (cnt_o),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last)
  );

  assign ofs_in[0] = src_ofs_i;
  assign ofs_in[1] = dst_ofs_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ofs
    blk_mover_ofs #(.OFS_W(OFS_W), .NARROW_W(NARROW_W)) u_ofs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .val_i    (ofs_in[g]),
      .narrow_i (load ? narrow_i : narrow_q),
      .step_i   (step),
      .desc_i   (desc_q),
      .ofs_o    (ofs_cur[g])
    );
  end

  // operand bytes arrive in swapped order: second is source, first is destination
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_bank_q <= '0;
      dst_bank_q <= '0;
      desc_q     <= 1'b0;
      narrow_q   <= 1'b0;
      dbank_q    <= '0;
    end else begin
      if (load) begin
        src_bank_q <= opnd_b_i;
        dst_bank_q <= opnd_a_i;
        desc_q     <= desc_i;
        narrow_q   <= narrow_i;
      end
      if (last) dbank_q <= dst_bank_q;
    end
  end

  assign mem_re_o    = (state == ST_RD);
  assign mem_we_o    = (state == ST_WR);
  assign mem_addr_o  = mem_we_o ? {dst_bank_q, ofs_cur[1]} : {src_bank_q, ofs_cur[0]};
  assign mem_wdata_o = mem_rdata_i;
  assign busy_o      = mem_re_o || mem_we_o;
  assign done_o      = (state == ST_FIN);
  assign src_ofs_o   = ofs_cur[0];
  assign dst_ofs_o   = ofs_cur[1];
  assign dbank_o     = dbank_q;
endmodule

// File: rtl/blk_mover_chk.sv
module blk_mover_chk #(
  parameter int BANK_W = 8,
  parameter int OFS_W  = 16,
  parameter int CNT_W  = 16,
  parameter int NARROW_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    narrow_i,
  input logic [BANK_W-1:0]       opnd_a_i,
  input logic [BANK_W-1:0]       opnd_b_i,
  input logic [BANK_W+OFS_W-1:0] mem_addr_o,
  input logic                    mem_re_o,
  input logic                    mem_we_o,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [OFS_W-1:0]        src_ofs_o,
  input logic [OFS_W-1:0]        dst_ofs_o,
  input logic [CNT_W-1:0]        cnt_o,
  input logic [BANK_W-1:0]       dbank_o
);
  logic [BANK_W-1:0] sb_q, db_q;
  logic              nw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb_q <= '0; db_q <= '0; nw_q <= 1'b0;
    end else if (start_i && !busy_o && !done_o) begin
      sb_q <= opnd_b_i; db_q <= opnd_a_i; nw_q <= narrow_i;
    end
  end

  p_rw_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_re_o && mem_we_o));
  p_rd_then_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> mem_we_o);
  p_src_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> mem_addr_o[BANK_W+OFS_W-1:OFS_W] == sb_q);
  p_dst_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[BANK_W+OFS_W-1:OFS_W] == db_q);
  p_cnt_dec_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> cnt_o == $past(cnt_o) - 1'b1);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(mem_we_o) && cnt_o == '1);
  p_narrow_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && nw_q) |-> (src_ofs_o[OFS_W-1:NARROW_W] == '0 && dst_ofs_o[OFS_W-1:NARROW_W] == '0));
  p_dbank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dbank_o == db_q);
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && start_i) |=> mem_we_o);
endmodule

bind blk_mover blk_mover_chk #(.BANK_W(BANK_W), .OFS_W(OFS_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .narrow_i(narrow_i),
  .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .mem_addr_o(mem_addr_o),
  .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .busy_o(busy_o), .done_o(done_o),
  .src_ofs_o(src_ofs_o), .dst_ofs_o(dst_ofs_o), .cnt_o(cnt_o), .dbank_o(dbank_o)
);

// File: tb/sim_blk_mover.sv
module sim_blk_mover;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, desc = 1'b0, narrow = 1'b0;
  logic [7:0]  opa = '0, opb = '0;
  logic [15:0] srco = '0, dsto = '0, cnt = '0;
  logic [23:0] addr;
  logic        re, we, busy, done;
  logic [7:0]  wdata, rdata;
  logic [15:0] src_out, dst_out, cnt_out;
  logic [7:0]  dbank;

  int checks = 0, errors = 0;
  logic [7:0]  mem_m [logic [23:0]];
  logic [7:0]  ref_m [logic [23:0]];
  logic [23:0] wlog[$];

  always #10 clk = ~clk;

  blk_mover u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .desc_i(desc), .narrow_i(narrow),
    .opnd_a_i(opa), .opnd_b_i(opb), .src_ofs_i(srco), .dst_ofs_i(dsto), .cnt_i(cnt),
    .mem_addr_o(addr), .mem_re_o(re), .mem_we_o(we), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .src_ofs_o(src_out),
    .dst_ofs_o(dst_out), .cnt_o(cnt_out), .dbank_o(dbank)
  );

  function automatic logic [7:0] pat(logic [23:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rd_m(logic [23:0] a);
    return mem_m.exists(a) ? mem_m[a] : pat(a);
  endfunction

  function automatic logic [7:0] rd_r(logic [23:0] a);
    return ref_m.exists(a) ? ref_m[a] : pat(a);
  endfunction

  always @(posedge clk) begin
    if (re) rdata <= rd_m(addr);
    if (we) begin
      mem_m[addr] = wdata;
      wlog.push_back(addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stepo(logic [15:0] o, bit d, bit n);
    logic [15:0] r;
    r = d ? o - 16'd1 : o + 16'd1;
    if (n) r[15:8] = 8'h00;
    return r;
  endfunction

  // one move: reference copy, run, compare; inject_start pulses start mid-run
  task automatic run_move(input string tag, input bit d, input bit n,
                          input logic [7:0] a, input logic [7:0] b,
                          input logic [15:0] s, input logic [15:0] t,
                          input logic [15:0] c, input bit inject_start);
    logic [15:0] es, et;
    logic [23:0] exp_w[$];
    int nbytes, busy_cyc, done_cyc;
    nbytes = int'(c) + 1;
    ref_m = mem_m;
    es = n ? {8'h00, s[7:0]} : s;
    et = n ? {8'h00, t[7:0]} : t;
    for (int i = 0; i < nbytes; i++) begin
      ref_m[{a, et}] = rd_r({b, es});
      exp_w.push_back({a, et});
      es = stepo(es, d, n);
      et = stepo(et, d, n);
    end
    wlog.delete();
    @(negedge clk);
    desc = d; narrow = n; opa = a; opb = b; srco = s; dsto = t; cnt = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cyc = 0; done_cyc = 0;
    for (int k = 0; k < 4 * nbytes + 8; k++) begin
      if (busy) busy_cyc++;
      if (done) done_cyc++;
      if (inject_start && k == 1) begin
        desc = ~d; opa = 8'hEE; opb = 8'hDD; cnt = 16'd0; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        chk(!busy, "R8", {tag, " busy low with done"}, busy, 0);
        chk(cnt_out == 16'hFFFF, "R1", {tag, " final count"}, cnt_out, 16'hFFFF);
        chk(src_out == es, "R5", {tag, " final src offset"}, src_out, es);
        chk(dst_out == et, "R5", {tag, " final dst offset"}, dst_out, et);
        chk(dbank == a, "R9", {tag, " data bank"}, dbank, a);
        @(negedge clk);
        chk(!done, "R8", {tag, " done one cycle"}, done, 0);
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done_cyc == 1, "R8", {tag, " done seen once"}, done_cyc, 1);
    chk(busy_cyc == 2 * nbytes, "R7", {tag, " busy cycles"}, busy_cyc, 2 * nbytes);
    chk(wlog.size() == nbytes, "R1", {tag, " bytes written"}, wlog.size(), nbytes);
    for (int i = 0; i < nbytes && i < wlog.size(); i++)
      chk(wlog[i] == exp_w[i], "R3", {tag, " write address order"}, wlog[i], exp_w[i]);
    for (int i = 0; i < nbytes; i++)
      chk(rd_m(exp_w[i]) == rd_r(exp_w[i]), "R3", {tag, " copied byte"},
          rd_m(exp_w[i]), rd_r(exp_w[i]));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !re && !we, "R11", "strobes after reset", {busy, done, re, we}, 0);
    chk(cnt_out == 0 && src_out == 0 && dst_out == 0 && dbank == 0, "R11",
        "registers after reset", {cnt_out, dbank}, 0);
  endtask

  task automatic t_single();   run_move("R1 one byte", 0, 0, 8'h12, 8'h34, 16'h1000, 16'h2000, 16'd0, 0); endtask
  task automatic t_banks();    run_move("R2 asc", 0, 0, 8'h12, 8'h34, 16'h0400, 16'h0800, 16'd5, 0); endtask
  task automatic t_desc();     run_move("R5 desc", 1, 0, 8'h01, 8'h02, 16'h0300, 16'h0310, 16'd3, 0); endtask
  task automatic t_narrow();   run_move("R4 narrow", 0, 1, 8'h05, 8'h06, 16'h12FE, 16'hABFD, 16'd3, 0); endtask
  task automatic t_narrow_d(); run_move("R4 narrow desc", 1, 1, 8'h07, 8'h07, 16'h7701, 16'h8880, 16'd2, 0); endtask
  task automatic t_wrap();     run_move("R6 wrap up", 0, 0, 8'h40, 8'h34, 16'hFFFE, 16'hFFFD, 16'd4, 0); endtask
  task automatic t_wrap_d();   run_move("R6 wrap down", 1, 0, 8'h41, 8'h42, 16'h0001, 16'h0000, 16'd3, 0); endtask
  task automatic t_overlap();  run_move("R3 overlap", 0, 0, 8'h20, 8'h20, 16'h0100, 16'h0101, 16'd3, 0); endtask
  task automatic t_ignore();   run_move("R10 start busy", 0, 0, 8'h50, 8'h51, 16'h0010, 16'h0020, 16'd4, 1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_banks();
    t_desc();
    t_narrow();
    t_narrow_d();
    t_wrap();
    t_wrap_d();
    t_overlap();
    t_ignore();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule